// File: doc/BRIEF.md
# Serial Configuration Daisy-Chain Shifter

This block is the serial configuration front end of one device in a chain of devices that all take their configuration from one shared serial stream. Each device takes its data input from the data output of the device before it. All devices share one configuration clock. The block hunts for a fixed 8-bit sync pattern. It then reads a 24-bit total-length field, and repeats both to its serial output so that every device further down the chain sees the same header.

After the header the block absorbs its own data frames and holds its serial output high while it does so. Devices further down the chain therefore never see the zero start bits that belong to this device. A run of leading ones before the first start bit is taken as idle, which is what a downstream device sees while upstream devices absorb their own frames. Each completed frame produces a one-cycle write strobe with a frame index and the payload bits. Once its own frames are in, the block passes every further bit through, until the running bit count reaches the length field. It then raises a done flag and drives its output high.

Top module: `cfg_chain_shifter`

## Requirements
- R1: Input bits are taken on the rising edge of `cclk`. The output bit that belongs to a taken input bit appears on `dout` at the next falling edge of `cclk`.
- R2: While hunting, each received bit is copied to `dout`. Bits before a complete 8-bit match of `PREAMBLE` change no other output and do not count.
- R3: The sync pattern and the 24-bit length field that follows it, sent most significant bit first, are copied unchanged to `dout`.
- R4: The bit count is 8 at the last sync bit and rises by one on every later bit. `done` goes high in the cycle after the bit whose count equals the length field, and stays high until reset.
- R5: After the length field, bits of value 1 are skipped as idle. The first 0 starts this device's first frame. From the end of the length field until the last own frame is complete, `dout` is 1.
- R6: A frame is `FRAME_BITS` bits: a start bit of 0, then `FRAME_BITS-1` payload bits, most significant first. On the last bit of a frame, `wr_en` pulses for one cycle with `wr_addr` set to the frame index (counting from 0) and `wr_data` set to the payload.
- R7: After `FRAMES` frames are stored, every further bit is copied to `dout`, up to and including the bit whose count equals the length field.
- R8: Once frames have started, a frame start bit of 1 raises `err`. No further writes follow, `dout` stays 1, and `err` stays high until reset.
- R9: Once `done` is high, `dout` is 1 and `wr_en` stays low, whatever arrives on `din`.
- R10: If the count reaches the length field while frames are still being loaded, loading stops there. A frame that completes on that bit is still written, and no later frame is written.
- R11: A synchronous reset returns the block to hunting and clears all counters. After reset, `wr_en`, `done` and `err` are 0 and `dout` is 1 from the next falling edge.
- R12: In a two-device chain with the second device fed from the first device's `dout`, each device stores only its own frames. Both devices reach `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Serial data toward the next device, updated on the falling edge |
| wr_en | output | 1 | One-cycle strobe for a completed frame |
| wr_addr | output | IDX_W | Index of the completed frame |
| wr_data | output | FRAME_BITS-1 | Payload of the completed frame |
| done | output | 1 | Length count reached |
| err | output | 1 | Bad frame start bit seen |

## Verification
The bench builds a two-device stream and compares the first device's output bit by bit. The header must come through unchanged, the device's own frame window must be solid ones, and the second device's frames and the trailer must pass through. A design that leaked its own start bits would make the second device store the first device's data. A design that left pass-through too early would hide the second device's frames. Other corner cases are covered as well. A length field that ends partway through the frames checks that loading stops on time, and an off-by-one bit counter would write an extra frame or raise done a cycle off. A near-miss sync pattern before the real one must be ignored. A bad start bit must latch the error, and a reset in mid-stream must bring the block back.

// File: rtl/cfg_chain_shifter.sv
module cfg_chain_shifter #(
  parameter logic [7:0] PREAMBLE   = 8'hB2,
  parameter int         LEN_W      = 24,
  parameter int         FRAME_BITS = 12,
  parameter int         FRAMES     = 4,
  localparam int        PAY_W      = FRAME_BITS - 1,
  localparam int        ACC_W      = PAY_W - 1,
  localparam int        POS_W      = $clog2(FRAME_BITS),
  localparam int        IDX_W      = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int        LB_W       = $clog2(LEN_W)
) (
  input  logic             cclk,
  input  logic             rst,
  input  logic             din,
  output logic             dout,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [PAY_W-1:0] wr_data,
  output logic             done,
  output logic             err
);

  typedef enum logic [2:0] {S_HUNT, S_LEN, S_IDLE, S_LOAD, S_FWD, S_DONE, S_ERR} st_t;

  st_t              state;
  logic [6:0]       win;
  logic [2:0]       hfill;
  logic [LEN_W-1:0] cnt, len;
  logic [LB_W-1:0]  lbits;
  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] fidx;
  logic [ACC_W-1:0] acc;
  logic             obit;

  logic [LEN_W-1:0] cnt_nx, len_nx;
  logic             hit, at_end, last_pos, last_frame, last_lbit;

  assign cnt_nx     = cnt + LEN_W'(1);
  assign len_nx     = {len[LEN_W-2:0], din};
  assign hit        = (hfill == 3'd7) && ({win, din} == PREAMBLE);
  assign at_end     = (cnt_nx == len);
  assign last_pos   = (pos == POS_W'(FRAME_BITS - 1));
  assign last_frame = (fidx == IDX_W'(FRAMES - 1));
  assign last_lbit  = (lbits == LB_W'(LEN_W - 1));
  assign done       = (state == S_DONE);
  assign err        = (state == S_ERR);

  always_ff @(posedge cclk) begin
    if (rst) begin
      state   <= S_HUNT;
      win     <= '0;
      hfill   <= '0;
      cnt     <= '0;
      len     <= '0;
      lbits   <= '0;
      pos     <= '0;
      fidx    <= '0;
      acc     <= '0;
      obit    <= 1'b1;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      obit  <= 1'b1;
      case (state)
        S_HUNT: begin
          obit <= din;
          win  <= {win[5:0], din};
          if (hfill != 3'd7) hfill <= hfill + 3'd1;
          if (hit) begin
            state <= S_LEN;
            cnt   <= LEN_W'(8);
            lbits <= '0;
          end
        end
        S_LEN: begin
          obit  <= din;
          len   <= len_nx;
          cnt   <= cnt_nx;
          lbits <= lbits + LB_W'(1);
          if (last_lbit) state <= (len_nx <= cnt_nx) ? S_DONE : S_IDLE;
        end
        S_IDLE: begin
          cnt <= cnt_nx;
          if (!din) begin
            state <= S_LOAD;
            pos   <= POS_W'(1);
          end
          if (at_end) state <= S_DONE;
        end
        S_LOAD: begin
          cnt <= cnt_nx;
          if (pos == '0) begin
            if (din) state <= S_ERR;
            else     pos   <= POS_W'(1);
          end else if (last_pos) begin
            wr_en   <= 1'b1;
            wr_addr <= fidx;
            wr_data <= {acc, din};
            pos     <= '0;
            if (last_frame) state <= S_FWD;
            else            fidx  <= fidx + IDX_W'(1);
          end else begin
            acc <= ACC_W'({acc, din});
            pos <= pos + POS_W'(1);
          end
          if (at_end) state <= S_DONE;
        end
        S_FWD: begin
          obit <= din;
          cnt  <= cnt_nx;
          if (at_end) state <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge cclk) dout <= obit;

endmodule

// File: rtl/cfg_chain_shifter_chk.sv
module cfg_chain_shifter_chk #(
  parameter int IDX_W = 1
) (
  input logic             cclk,
  input logic             rst,
  input logic             dout,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_addr,
  input logic             done,
  input logic             err
);

  // R4
  done_sticky_chk: assert property (@(posedge cclk) disable iff (rst) done |=> done);

  // R8
  err_sticky_chk: assert property (@(posedge cclk) disable iff (rst) err |=> err);

  // R8
  err_no_write_chk: assert property (@(posedge cclk) disable iff (rst) err |=> !wr_en);

  // R9
  done_no_write_chk: assert property (@(posedge cclk) disable iff (rst) done |=> !wr_en);

  // R9
  done_dout_high_chk: assert property (@(posedge cclk) disable iff (rst) (done && $past(done)) |-> dout);

  // R6
  wr_pulse_chk: assert property (@(posedge cclk) disable iff (rst) wr_en |=> (!wr_en || $past(wr_addr) != wr_addr));

  // R4
  done_err_excl_chk: assert property (@(posedge cclk) disable iff (rst) !(done && err));

  // R11
  reset_clear_chk: assert property (@(posedge cclk) rst |=> (!done && !err && !wr_en));

endmodule

bind cfg_chain_shifter cfg_chain_shifter_chk #(.IDX_W(IDX_W)) u_chk (
  .cclk(cclk), .rst(rst), .dout(dout), .wr_en(wr_en),
  .wr_addr(wr_addr), .done(done), .err(err)
);

// File: tb/sim_cfg_chain_shifter.sv
`timescale 1ns/1ps
module sim_cfg_chain_shifter;
  localparam int FB = 8;
  localparam int NF = 2;
  localparam int PW = FB - 1;
  localparam logic [7:0] PRE = 8'hB2;
  // bit 7: device (0 first, 1 second), bits 6:0 payload
  localparam logic [7:0] VEC [4] = '{8'h4B, 8'h01, 8'hFF, 8'hB0};

  logic clk = 1'b0, rst = 1'b1, din = 1'b1;
  logic dout0, dout1, we0, we1, dn0, dn1, er0, er1;
  logic [0:0] wa0, wa1;
  logic [PW-1:0] wd0, wd1;

  always #2 clk = ~clk;

  cfg_chain_shifter #(.PREAMBLE(PRE), .FRAME_BITS(FB), .FRAMES(NF)) u0 (
    .cclk(clk), .rst(rst), .din(din), .dout(dout0), .wr_en(we0),
    .wr_addr(wa0), .wr_data(wd0), .done(dn0), .err(er0));

  cfg_chain_shifter #(.PREAMBLE(PRE), .FRAME_BITS(FB), .FRAMES(NF)) u1 (
    .cclk(clk), .rst(rst), .din(dout0), .dout(dout1), .wr_en(we1),
    .wr_addr(wa1), .wr_data(wd1), .done(dn1), .err(er1));

  int checks = 0, fails = 0, idx = 0, na = 0, nb = 0;
  logic sent [0:255];
  logic dlog [0:255];
  logic dnlog[0:255];
  logic [PW-1:0] ad [0:15], bd [0:15];
  logic [0:0]    aa [0:15], ba [0:15];

  always @(negedge clk) begin
    if (!rst && we0 && na < 16) begin aa[na] = wa0; ad[na] = wd0; na++; end
    if (!rst && we1 && nb < 16) begin ba[nb] = wa1; bd[nb] = wd1; nb++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    din = b;
    sent[idx] = b;
    @(posedge clk);
    @(negedge clk);
    #1;
    dlog[idx]  = dout0;
    dnlog[idx] = dn0;
    idx++;
  endtask

  task automatic send_val(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_frame(input logic [PW-1:0] p);
    send_bit(1'b0);
    send_val(32'(p), PW);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst = 1'b1;
    din = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    rst = 1'b0;
    idx = 0;
  endtask

  // compare u0 output log to sent bits over [lo,hi]; want_ones selects all-ones check
  task automatic cmp_range(input string req, input int lo, input int hi, input logic want_ones);
    int bad = -1;
    for (int i = lo; i <= hi; i++) begin
      logic e = want_ones ? 1'b1 : sent[i];
      if (bad < 0 && dlog[i] !== e) bad = i;
    end
    if (bad < 0) chk(req, 0, 0);
    else chk(req, {31'd0, dlog[bad]}, want_ones ? 32'd1 : {31'd0, sent[bad]});
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base, ea, eb;
    // ---- reset state (R11)
    do_reset();
    chk("R11 dout after reset", dout0, 1);
    chk("R11 wr_en after reset", we0, 0);
    chk("R11 done after reset", dn0, 0);
    chk("R11 err after reset", er0, 0);

    // ---- two-device composite stream, walked from the vector table
    send_val(32'hF, 4);          // idle bits 0..3
    send_val(32'(PRE), 8);       // 4..11
    send_val(32'd74, 24);        // 12..35
    for (int i = 0; i < 4; i++) send_frame(VEC[i][6:0]);   // 36..67
    send_val(32'b1011100101, 10); // trailer 68..77
    chk("R4 done low before last bit", dnlog[76], 0);
    chk("R4 done after last counted bit", dnlog[77], 1);
    cmp_range("R1 R2 R3 header echoed", 0, 35, 1'b0);
    cmp_range("R5 dout high over own frames", 36, 51, 1'b1);
    cmp_range("R7 pass-through after own frames", 52, 77, 1'b0);
    send_val(32'h0, 4);          // zeros after done: 78..81
    cmp_range("R9 dout high after done", 78, 81, 1'b1);
    chk("R9 done held", dn0, 1);
    chk("R6 first device write count", na, 2);
    chk("R12 second device write count", nb, 2);
    ea = 0; eb = 0;
    for (int i = 0; i < 4; i++) begin
      if (!VEC[i][7]) begin
        chk("R6 first device addr", aa[ea], ea[0:0]);
        chk("R6 first device data", ad[ea], VEC[i][6:0]);
        ea++;
      end else begin
        chk("R12 second device addr", ba[eb], eb[0:0]);
        chk("R12 second device data", bd[eb], VEC[i][6:0]);
        eb++;
      end
    end
    chk("R12 second device done", dn1, 1);
    chk("R12 no error in chain", {er0, er1}, 0);

    // ---- bad start bit (R8), then mid-stream reset (R11)
    do_reset();
    base = na;
    send_val(32'(PRE), 8);
    send_val(32'd200, 24);
    send_frame(7'h2C);
    chk("R8 err low before bad start", er0, 0);
    send_bit(1'b1);
    chk("R8 err on bad start bit", er0, 1);
    send_val(32'h0, 7);
    send_frame(7'h55);
    chk("R8 no write after error", na - base, 1);
    cmp_range("R8 dout high after error", 40, idx - 1, 1'b1);
    chk("R8 err held", er0, 1);
    do_reset();
    chk("R11 err cleared by reset", er0, 0);
    chk("R11 dout high after reset", dout0, 1);

    // ---- near-miss prefix and short length (R2, R10)
    base = na;
    send_val(32'hB3, 8);         // 0..7
    chk("R2 near-miss prefix no effect", {dn0, er0, 30'(na - base)}, 0);
    send_val(32'(PRE), 8);       // 8..15
    send_val(32'd40, 24);        // 16..39
    cmp_range("R2 R3 prefix and header echoed", 0, 39, 1'b0);
    send_frame(7'h66);           // 40..47, count 33..40
    chk("R10 done low one bit early", dnlog[46], 0);
    chk("R10 done at length", dnlog[47], 1);
    send_frame(7'h11);
    chk("R10 only one frame written", na - base, 1);
    chk("R10 frame data", ad[base], 7'h66);
    chk("R10 frame addr", aa[base], 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule